// File: doc/BRIEF.md
# Postfix Evaluation Stack with Register Window and Spill Memory

This block evaluates postfix (reverse Polish) arithmetic programs one instruction at a time. An instruction either pushes a 16-bit value, discards the top entry, or applies a binary operator (add, subtract, multiply, divide) to the two topmost entries. The operator's result replaces both operands. Only the upper `N` entries of the stack sit in a register window. Deeper entries are moved out to a single-port synchronous memory supplied by the surrounding logic, and they are brought back when the window drains.

Memory traffic is driven only by the window boundary. Pushing onto a full window stores the deepest window entry before the new value goes in. When a pop or an operator consumes an entry while spilled entries exist, one entry is fetched back. The total capacity is `N + MEM_DEPTH` entries, and programs must stay within it. Two counters report how many stores and fetches have taken place.

Instructions arrive over a valid/ready handshake. An instruction is taken on a rising edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold its instruction, and nothing on `in_op`/`in_data` has any effect. `in_ready` is low only while a memory cycle is in progress. The memory writes on the edge where `mem_en` and `mem_we` are both high. A read started with `mem_en` high and `mem_we` low returns `mem_rdata` in the following cycle.

Top module: `stack_eval`

## Requirements
- R1: Reset behaviour. After reset, `in_ready` is 1. `tos`, both counters, `done` and both error flags are 0, and `mem_en` is 0. Whenever the stack is empty, `tos` reads 0.
- R2: Push, opcode 0, into a window holding fewer than `N` entries. `tos` becomes the pushed value one cycle later. No memory cycle takes place and `in_ready` stays high.
- R3: Binary operators use opcodes 2 add, 3 subtract, 4 multiply and 5 divide. Each computes (next-to-top op top) and replaces both entries with the result. Arithmetic is 16-bit two's complement. Multiply keeps the low 16 bits, and divide is signed and truncates toward zero.
- R4: Pushing onto a full window runs one memory write cycle with `in_ready` low for that cycle. The write stores the deepest window entry at the spill pointer (number of entries already in memory), then increments the pointer. The new value becomes `tos` and `spill_count` increments by one.
- R5: Pop is opcode 1. When a pop or an operator is accepted while memory holds spilled entries, exactly one entry is fetched back. This takes one read cycle at address (spill pointer − 1) followed by one capture cycle, with `in_ready` low for both. The fetched entry becomes the deepest window entry, and `fill_count` increments by one.
- R6: With `N`=2, evaluating `a b c * + a d c * + e - /` produces exactly 4 spill stores and 4 refill fetches, and leaves the correct quotient on top.
- R7: An operator accepted while the stack holds fewer than 2 entries, or a pop on an empty stack, sets `err_underflow`. The flag stays set until reset. The stack, `tos` and the counters are left unchanged.
- R8: Divide by zero yields 0xFFFF as the result and sets `err_divzero`, which stays set until reset.
- R9: Opcode 6 sets `done`, which stays set until reset. Opcode 7 is accepted and changes nothing.
- R10: An instruction presented while `in_ready` is low is not consumed. `mem_en` is 0 whenever `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_op | input | 3 | Opcode (0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div, 6 end, 7 no-op) |
| in_data | input | W | Value for push |
| tos | output | W | Current top-of-stack entry, 0 when empty |
| done | output | 1 | Sticky: end instruction seen |
| err_underflow | output | 1 | Sticky: operand shortage |
| err_divzero | output | 1 | Sticky: division by zero |
| spill_count | output | CNTW | Number of spill stores since reset |
| fill_count | output | CNTW | Number of refill fetches since reset |
| mem_en | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | log2(MEM_DEPTH) | Memory address |
| mem_wdata | output | W | Data to store |
| mem_rdata | input | W | Read data, valid the cycle after a read request |

## Verification
A wrong spill pointer or a lost store can stay hidden for many instructions. It only shows when that entry is fetched back and reaches `tos`. For that reason, address, direction and stored data are compared on the very cycle of each memory access, not only at the final result. A wrong window occupancy first shows as a missing or extra busy cycle on `in_ready`. It shows no later than the next push at the window boundary or the next operator while memory holds entries, so `in_ready` is compared on every clock. The counters and sticky flags are compared whenever the unit is idle.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_END  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  // Window update command issued by the controller each cycle
  typedef enum logic [2:0] {
    WC_HOLD,
    WC_PUSH,      // write above current top
    WC_SHIFT_IN,  // drop deepest, shift down, insert at top slot
    WC_DROP,      // remove top
    WC_MERGE,     // overwrite next-to-top with result, remove top
    WC_REFILL     // shift up, insert at deepest slot
  } wcmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SPILL,
    S_FILL_RD,
    S_FILL_WR
  } st_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] lhs,   // next-to-top
  input  logic [W-1:0] rhs,   // top
  output logic [W-1:0] res,
  output logic         dz
);

  logic [2*W-1:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};
    dz   = 1'b0;
    res  = rhs;
    unique case (op)
      OP_ADD: res = lhs + rhs;
      OP_SUB: res = lhs - rhs;
      OP_MUL: res = prod[W-1:0];
      OP_DIV: begin
        if (rhs == '0) begin
          res = '1;
          dz  = 1'b1;
        end else begin
          res = $signed(lhs) / $signed(rhs);
        end
      end
      default: res = rhs;
    endcase
  end

endmodule

// File: rtl/stk_window.sv
module stk_window
  import stk_pkg::*;
#(
  parameter int N = 2,
  parameter int W = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wcmd_e         cmd,
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  top,
  output logic [W-1:0]  next,
  output logic [W-1:0]  bottom
);

  logic [W-1:0]  ent_q [N];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else begin
      unique case (cmd)
        WC_PUSH: begin
          for (int i = 0; i < N; i++)
            if (cnt_q == CW'(i)) ent_q[i] <= din;
          cnt_q <= cnt_q + 1'b1;
        end
        WC_SHIFT_IN: begin
          for (int i = 0; i < N - 1; i++) ent_q[i] <= ent_q[i+1];
          ent_q[N-1] <= din;
        end
        WC_DROP: cnt_q <= cnt_q - 1'b1;
        WC_MERGE: begin
          for (int i = 0; i < N; i++)
            if (cnt_q == CW'(i + 2)) ent_q[i] <= din;
          cnt_q <= cnt_q - 1'b1;
        end
        WC_REFILL: begin
          for (int i = 1; i < N; i++) ent_q[i] <= ent_q[i-1];
          ent_q[0] <= din;
          cnt_q    <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    top  = '0;
    next = '0;
    for (int i = 0; i < N; i++) begin
      if (cnt_q == CW'(i + 1)) top  = ent_q[i];
      if (cnt_q == CW'(i + 2)) next = ent_q[i];
    end
  end

  assign cnt    = cnt_q;
  assign bottom = ent_q[0];

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(N));

  // R2
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WC_PUSH |-> cnt_q < CW'(N));

  // R5
  refill_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WC_REFILL |-> cnt_q < CW'(N));

  // R4
  shift_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WC_SHIFT_IN |-> cnt_q == CW'(N));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int N         = 2,
  parameter int W         = 16,
  parameter int MEM_DEPTH = 16,
  parameter int CNTW      = 16,
  localparam int CW  = $clog2(N + 1),
  localparam int AW  = $clog2(MEM_DEPTH),
  localparam int SPW = $clog2(MEM_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  op_e             op,
  input  logic [W-1:0]    in_data,
  input  logic [CW-1:0]   win_cnt,
  input  logic [W-1:0]    win_bottom,
  input  logic [W-1:0]    alu_res,
  input  logic            alu_dz,
  output wcmd_e           win_cmd,
  output logic [W-1:0]    win_din,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic            done,
  output logic            err_uf,
  output logic            err_dz,
  output logic [CNTW-1:0] spill_count,
  output logic [CNTW-1:0] fill_count
);

  st_e             st_q, st_d;
  logic [W-1:0]    pend_q;
  logic [SPW-1:0]  sp_q, sp_dec;
  logic [CNTW-1:0] spill_q, fill_q;
  logic            done_q, uf_q, dz_q;
  logic            accept, win_full, mem_held;
  logic            set_uf, set_dz, set_done, latch_pend;

  assign in_ready  = (st_q == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign win_full  = (win_cnt == CW'(N));
  assign mem_held  = (sp_q != '0);
  assign sp_dec    = sp_q - 1'b1;
  assign mem_wdata = win_bottom;

  always_comb begin
    st_d       = st_q;
    win_cmd    = WC_HOLD;
    win_din    = in_data;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = sp_q[AW-1:0];
    set_uf     = 1'b0;
    set_dz     = 1'b0;
    set_done   = 1'b0;
    latch_pend = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_PUSH: begin
              if (win_full) begin
                st_d       = S_SPILL;
                latch_pend = 1'b1;
              end else begin
                win_cmd = WC_PUSH;
              end
            end
            OP_POP: begin
              if (win_cnt == '0) set_uf = 1'b1;
              else begin
                win_cmd = WC_DROP;
                if (mem_held) st_d = S_FILL_RD;
              end
            end
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
              if (win_cnt < CW'(2)) set_uf = 1'b1;
              else begin
                win_cmd = WC_MERGE;
                win_din = alu_res;
                set_dz  = alu_dz;
                if (mem_held) st_d = S_FILL_RD;
              end
            end
            OP_END:  set_done = 1'b1;
            default: ;
          endcase
        end
      end
      S_SPILL: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        win_cmd = WC_SHIFT_IN;
        win_din = pend_q;
        st_d    = S_IDLE;
      end
      S_FILL_RD: begin
        mem_en   = 1'b1;
        mem_addr = sp_dec[AW-1:0];
        st_d     = S_FILL_WR;
      end
      S_FILL_WR: begin
        win_cmd = WC_REFILL;
        win_din = mem_rdata;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      pend_q  <= '0;
      sp_q    <= '0;
      spill_q <= '0;
      fill_q  <= '0;
      done_q  <= 1'b0;
      uf_q    <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (latch_pend) pend_q <= in_data;
      if (st_q == S_SPILL) begin
        sp_q    <= sp_q + 1'b1;
        spill_q <= spill_q + 1'b1;
      end
      if (st_q == S_FILL_RD) sp_q   <= sp_dec;
      if (st_q == S_FILL_WR) fill_q <= fill_q + 1'b1;
      if (set_done) done_q <= 1'b1;
      if (set_uf)   uf_q   <= 1'b1;
      if (set_dz)   dz_q   <= 1'b1;
    end
  end

  assign done        = done_q;
  assign err_uf      = uf_q;
  assign err_dz      = dz_q;
  assign spill_count = spill_q;
  assign fill_count  = fill_q;

  // R4
  spill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PUSH && win_full |=> !in_ready && mem_en && mem_we);

  // R5
  fill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_POP || op == OP_ADD || op == OP_SUB || op == OP_MUL || op == OP_DIV)
      && win_cnt >= CW'(2) && mem_held
      |=> mem_en && !mem_we && mem_addr == AW'($past(sp_q) - 1'b1));

  // R5
  idle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && mem_held |-> win_full);

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fill_q == $past(fill_q) || fill_q == $past(fill_q) + 1'b1);

  // R7
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |=> uf_q);

  // R8
  dz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_DIV && win_cnt >= CW'(2) && alu_dz |=> dz_q && win_cmd == WC_HOLD);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R10
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_en);

endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stk_pkg::*;
#(
  parameter int N         = 2,
  parameter int W         = 16,
  parameter int MEM_DEPTH = 16,
  parameter int CNTW      = 16,
  localparam int CW = $clog2(N + 1),
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [W-1:0]    in_data,
  output logic [W-1:0]    tos,
  output logic            done,
  output logic            err_underflow,
  output logic            err_divzero,
  output logic [CNTW-1:0] spill_count,
  output logic [CNTW-1:0] fill_count,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata
);

  op_e           op;
  wcmd_e         win_cmd;
  logic [W-1:0]  win_din, win_top, win_next, win_bottom, alu_res;
  logic [CW-1:0] win_cnt;
  logic          alu_dz;

  assign op = op_e'(in_op);

  stk_window #(.N(N), .W(W)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (win_cmd),
    .din    (win_din),
    .cnt    (win_cnt),
    .top    (win_top),
    .next   (win_next),
    .bottom (win_bottom)
  );

  stk_alu #(.W(W)) u_alu (
    .op  (op),
    .lhs (win_next),
    .rhs (win_top),
    .res (alu_res),
    .dz  (alu_dz)
  );

  stk_ctrl #(.N(N), .W(W), .MEM_DEPTH(MEM_DEPTH), .CNTW(CNTW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .op          (op),
    .in_data     (in_data),
    .win_cnt     (win_cnt),
    .win_bottom  (win_bottom),
    .alu_res     (alu_res),
    .alu_dz      (alu_dz),
    .win_cmd     (win_cmd),
    .win_din     (win_din),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .err_uf      (err_underflow),
    .err_dz      (err_divzero),
    .spill_count (spill_count),
    .fill_count  (fill_count)
  );

  assign tos = win_top;

endmodule

// File: tb/test_stack_eval.sv
`timescale 1ns/1ps
module test_stack_eval;
  localparam int N = 2, W = 16, MD = 16, CNTW = 16, AW = $clog2(MD);
  localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, ADD = 3'd2, SUB = 3'd3,
                         MUL = 3'd4, DIV = 3'd5, FIN = 3'd6, NOP = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_op = 3'd0;
  logic [W-1:0] in_data = '0, tos, mem_wdata, mem_rdata;
  logic done, err_underflow, err_divzero, mem_en, mem_we;
  logic [CNTW-1:0] spill_count, fill_count;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem [MD];

  always #2.5 clk = ~clk;

  stack_eval #(.N(N), .W(W), .MEM_DEPTH(MD), .CNTW(CNTW)) i_stack_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .tos(tos), .done(done),
    .err_underflow(err_underflow), .err_divzero(err_divzero),
    .spill_count(spill_count), .fill_count(fill_count),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  // reference model
  logic [15:0] stk[$];
  int exp_spill = 0, exp_fill = 0;
  bit exp_uf = 0, exp_dz = 0, exp_done = 0;
  int checks = 0, fails = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "in_ready", int'(in_ready), 1);
    check(req, "tos", int'(tos), (stk.size() > 0) ? int'(stk[stk.size()-1]) : 0);
    check(req, "spill_count", int'(spill_count), exp_spill);
    check(req, "fill_count", int'(fill_count), exp_fill);
    check(req, "err_underflow", int'(err_underflow), int'(exp_uf));
    check(req, "err_divzero", int'(err_divzero), int'(exp_dz));
    check(req, "done", int'(done), int'(exp_done));
    check(req, "mem_en idle", int'(mem_en), 0);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] d, input string req);
    int busy, sz, addr, ia, ib;
    logic [15:0] a, b, r, wexp;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d;
    check(req, "ready before accept", int'(in_ready), 1);
    @(posedge clk);
    sz = stk.size(); busy = 0; addr = 0; wexp = '0;
    case (op)
      PUSH: begin
        if (sz >= N) begin busy = 1; addr = sz - N; wexp = stk[sz-N]; exp_spill++; end
        stk.push_back(d);
      end
      POP: begin
        if (sz == 0) exp_uf = 1;
        else begin
          if (sz > N) begin busy = 2; addr = sz - N - 1; exp_fill++; end
          void'(stk.pop_back());
        end
      end
      ADD, SUB, MUL, DIV: begin
        if (sz < 2) exp_uf = 1;
        else begin
          b = stk.pop_back(); a = stk.pop_back();
          ia = int'($signed(a)); ib = int'($signed(b));
          case (op)
            ADD: r = 16'(ia + ib);
            SUB: r = 16'(ia - ib);
            MUL: r = 16'(ia * ib);
            default: begin
              if (ib == 0) begin r = 16'hFFFF; exp_dz = 1; end
              else r = 16'(ia / ib);
            end
          endcase
          stk.push_back(r);
          if (sz > N) begin busy = 2; addr = sz - N - 1; exp_fill++; end
        end
      end
      FIN: exp_done = 1;
      default: ;
    endcase
    @(negedge clk);
    for (int i = 0; i < busy; i++) begin
      check(req, "in_ready busy", int'(in_ready), 0);
      if (i == 0) begin
        check(req, "mem_en", int'(mem_en), 1);
        check(req, "mem_we", int'(mem_we), (busy == 1) ? 1 : 0);
        check(req, "mem_addr", int'(mem_addr), addr);
        if (busy == 1) check(req, "mem_wdata", int'(mem_wdata), int'(wexp));
      end
      in_valid = 1'b1; in_op = PUSH; in_data = 16'h7777;  // R10 junk while stalled
      @(negedge clk);
    end
    in_valid = 1'b0;
    compare_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R6: (7 + 3*5) / (7 + 2*5 - 4) = 1
    issue(PUSH, 16'd7, "R2");
    issue(PUSH, 16'd3, "R2");
    issue(PUSH, 16'd5, "R4");
    issue(MUL,  16'd0, "R5");
    issue(ADD,  16'd0, "R3");
    issue(PUSH, 16'd7, "R2");
    issue(PUSH, 16'd2, "R4");
    issue(PUSH, 16'd5, "R4");
    issue(MUL,  16'd0, "R5");
    issue(ADD,  16'd0, "R5");
    issue(PUSH, 16'd4, "R4");
    issue(SUB,  16'd0, "R5");
    issue(DIV,  16'd0, "R6");
    check("R6", "spill total", int'(spill_count), 4);
    check("R6", "fill total", int'(fill_count), 4);
    check("R6", "quotient", int'(tos), 1);
    issue(POP, 16'd0, "R1");

    // R7 underflow keeps state
    issue(ADD,  16'd0, "R7");
    issue(PUSH, 16'd9, "R7");
    issue(SUB,  16'd0, "R7");
    issue(POP,  16'd0, "R7");
    issue(POP,  16'd0, "R7");

    // R3 ordering and wrap
    issue(PUSH, 16'd10, "R3");
    issue(PUSH, 16'd3, "R3");
    issue(SUB,  16'd0, "R3");
    issue(PUSH, 16'd300, "R3");
    issue(PUSH, 16'd300, "R3");
    issue(MUL,  16'd0, "R3");
    issue(PUSH, 16'd1000, "R3");
    issue(PUSH, 16'hFFF9, "R3");
    issue(DIV,  16'd0, "R3");
    issue(PUSH, 16'hFFFF, "R3");
    issue(PUSH, 16'h8000, "R3");
    issue(ADD,  16'd0, "R3");

    // R8 divide by zero
    issue(PUSH, 16'd5, "R8");
    issue(PUSH, 16'd0, "R8");
    issue(DIV,  16'd0, "R8");

    // R4/R5 deep spill and refill
    for (int k = 0; k < 7; k++) issue(PUSH, 16'(16'h0A00 + k), "R4");
    for (int k = 0; k < 13; k++) issue(POP, 16'd0, "R5");
    check("R1", "empty tos", int'(tos), 0);

    // R9 end and no-op
    issue(PUSH, 16'd42, "R9");
    issue(NOP,  16'd0, "R9");
    issue(FIN,  16'd0, "R9");
    issue(NOP,  16'd0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule